// File: doc/BRIEF.md
# Two-Content Distance Rule Matcher

This block checks one intrusion rule against a payload stream that arrives one byte per clock. The rule has two fixed byte strings: a leading content and a trailing content. Spotting the trailing content is not enough. The rule fires only when the trailing content follows a leading content in the same flow, and only inside a bounded byte window. Both strings, the window size and the counter width are build-time parameters. The default rule looks for "ab" and then "cde", with a window of 10 bytes.

Each string has a chain of prefix flops. Each flop is set by the flop before it ANDed with a per-position character compare. A flow byte counter restarts on every start-of-flow pulse and advances on every valid byte. The counter value is latched when the leading content completes. A parameter picks how the window is measured:

- Relative mode measures from the latest leading content.
- Absolute mode measures from the start of the flow.

Top module: `rm_dual_content_rule`

## Requirements
- R1: While reset is active, and in the first cycle after it, `first_hit_o` and `rule_hit_o` are 0 and `match_ofs_o` is 0.
- R2: `first_hit_o` is a one-cycle pulse in the clock cycle after the last byte of every occurrence of the leading content ("ab").
- R3: In relative mode, `rule_hit_o` pulses for one cycle in the clock cycle after the last byte of the trailing content ("cde"). This happens only when that byte's flow offset minus the flow offset of the latest leading content's last byte is below `MAX_DIST`. With the default of 10, a difference of 9 fires and differences of 10 and 11 do not.
- R4: A trailing content with no leading content earlier in the same flow never produces `rule_hit_o`.
- R5: A repeated leading content replaces the stored offset, so the window is measured from the most recent occurrence.
- R6: `flow_start_i` restarts the byte counter and clears the partial-match flops and the leading-content-seen state. A valid byte in the same cycle is flow offset 0 of the new flow. It is matched with no prefix carried over from the old flow.
- R7: Cycles with `chr_vld_i` low do not advance the byte counter and do not break a partial match. A content split by idle cycles still matches, with offsets counted in valid bytes only.
- R8: `match_ofs_o` is the flow offset of the trailing content's last byte, where the first valid byte of a flow is offset 0. It updates together with `rule_hit_o` and holds its value otherwise.
- R9: In absolute mode, the rule fires when a leading content has been seen in the flow and the trailing content's last byte has a flow offset below `MAX_DIST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_start_i | input | 1 | Start-of-flow pulse; restarts counting and matching |
| chr_vld_i | input | 1 | Payload byte valid |
| chr_i | input | 8 | Payload byte |
| first_hit_o | output | 1 | Leading content completed on the previous byte |
| rule_hit_o | output | 1 | Rule matched on the previous byte |
| match_ofs_o | output | CNT_W | Flow offset of the last byte of the matched trailing content |

## Verification
A start-of-flow pulse and a valid payload byte can fall in the same cycle. In that cycle the restart of counter and state must take effect before the byte is counted and compared. The bench provokes this case three ways:

- It ends a flow partway through "a" and starts the next flow with "b".
- It ends a flow after a full "ab" and starts the next flow with "cde".
- It starts a flow directly with "abcde".

The first two cases must give no hit of either kind. The third must report offset 4, which shows that the pulse byte was counted as offset 0.

// File: rtl/rm_pkg.sv
package rm_pkg;

   localparam int CHAR_W = 8;

   typedef logic [CHAR_W-1:0] char_t;

   // Reference point for the distance window
   typedef enum logic {
      POS_RELATIVE = 1'b0,   // measured from the latest leading content
      POS_ABSOLUTE = 1'b1    // measured from the flow start
   } pos_mode_e;

endpackage

// File: rtl/rm_pattern_match.sv
// Prefix-chain matcher for one fixed string. hit_o is combinational and is
// high during the cycle in which the last byte of the string is presented.
module rm_pattern_match #(
   parameter int                        LEN = 2,
   parameter logic [rm_pkg::CHAR_W*LEN-1:0] PAT = "ab"
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flow_start_i,
   input  logic          chr_vld_i,
   input  rm_pkg::char_t chr_i,
   output logic          hit_o
);

   localparam int CW = rm_pkg::CHAR_W;

   logic [LEN-1:0] eq;

   // One comparator per string position; position 0 is the first byte.
   for (genvar k = 0; k < LEN; k++) begin : g_cmp
      assign eq[k] = (chr_i == PAT[CW*(LEN-1-k) +: CW]);
   end

   if (LEN == 1) begin : g_single
      assign hit_o = chr_vld_i & eq[0];
   end else begin : g_chain
      logic [LEN-2:0] pm_q, pm_d, prev;

      always_comb begin
         prev = flow_start_i ? '0 : pm_q;
         pm_d = prev;
         if (chr_vld_i) begin
            pm_d[0] = eq[0];
            for (int k = 1; k < LEN - 1; k++) begin
               pm_d[k] = prev[k-1] & eq[k];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pm_q <= '0;
         else        pm_q <= pm_d;
      end

      assign hit_o = chr_vld_i & prev[LEN-2] & eq[LEN-1];
   end

endmodule

// File: rtl/rm_dist_gate.sv
// Window compare; the mode parameter selects the reference point.
module rm_dist_gate #(
   parameter int                CNT_W    = 16,
   parameter int                MAX_DIST = 10,
   parameter rm_pkg::pos_mode_e POS_MODE = rm_pkg::POS_RELATIVE
) (
   input  logic [CNT_W-1:0] idx_i,
   input  logic [CNT_W-1:0] ref_i,
   output logic             in_range_o
);

   localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_DIST);

   if (POS_MODE == rm_pkg::POS_ABSOLUTE) begin : g_abs
      logic unused_ref;
      assign unused_ref = ^ref_i;
      assign in_range_o = (idx_i < LIM);
   end else begin : g_rel
      logic [CNT_W-1:0] span;
      assign span       = idx_i - ref_i;
      assign in_range_o = (span < LIM);
   end

endmodule

// File: rtl/rm_dual_content_rule.sv
module rm_dual_content_rule #(
   parameter int                            LEN_A    = 2,
   parameter logic [rm_pkg::CHAR_W*LEN_A-1:0] PAT_A  = "ab",
   parameter int                            LEN_B    = 3,
   parameter logic [rm_pkg::CHAR_W*LEN_B-1:0] PAT_B  = "cde",
   parameter int                            CNT_W    = 16,
   parameter int                            MAX_DIST = 10,
   parameter rm_pkg::pos_mode_e             POS_MODE = rm_pkg::POS_RELATIVE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flow_start_i,
   input  logic             chr_vld_i,
   input  logic [7:0]       chr_i,
   output logic             first_hit_o,
   output logic             rule_hit_o,
   output logic [CNT_W-1:0] match_ofs_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      assert (LEN_A >= 1 && LEN_B >= 1)
         else $error("rm_dual_content_rule: content lengths must be at least 1");
      assert (CNT_W >= 2 && CNT_W <= 31)
         else $error("rm_dual_content_rule: CNT_W out of range");
      assert (MAX_DIST >= 1 && MAX_DIST < (1 << CNT_W))
         else $error("rm_dual_content_rule: MAX_DIST does not fit CNT_W");
   end

   logic             hit_a, hit_b, in_range;
   logic             seen_q, seen_eff, fire;
   logic [CNT_W-1:0] cnt_q, snap_q, idx, ref_pt;

   rm_pattern_match #(.LEN(LEN_A), .PAT(PAT_A)) u_lead (
      .clk(clk), .rst_n(rst_n), .flow_start_i(flow_start_i),
      .chr_vld_i(chr_vld_i), .chr_i(chr_i), .hit_o(hit_a)
   );

   rm_pattern_match #(.LEN(LEN_B), .PAT(PAT_B)) u_trail (
      .clk(clk), .rst_n(rst_n), .flow_start_i(flow_start_i),
      .chr_vld_i(chr_vld_i), .chr_i(chr_i), .hit_o(hit_b)
   );

   // Offset of the byte presented this cycle.
   assign idx      = flow_start_i ? '0 : cnt_q;
   assign seen_eff = (seen_q & ~flow_start_i) | hit_a;
   assign ref_pt   = hit_a ? idx : snap_q;

   rm_dist_gate #(.CNT_W(CNT_W), .MAX_DIST(MAX_DIST), .POS_MODE(POS_MODE)) u_gate (
      .idx_i(idx), .ref_i(ref_pt), .in_range_o(in_range)
   );

   assign fire = hit_b & seen_eff & in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         snap_q      <= '0;
         seen_q      <= 1'b0;
         first_hit_o <= 1'b0;
         rule_hit_o  <= 1'b0;
         match_ofs_o <= '0;
      end else begin
         if (chr_vld_i) cnt_q <= (idx == CNT_MAX) ? idx : idx + 1'b1;
         else           cnt_q <= idx;
         if (hit_a) snap_q <= idx;
         seen_q      <= seen_eff;
         first_hit_o <= hit_a;
         rule_hit_o  <= fire;
         if (fire) match_ofs_o <= idx;
      end
   end

endmodule

// File: rtl/rm_rule_checker.sv
module rm_rule_checker #(
   parameter int CNT_W    = 16,
   parameter int MAX_DIST = 10,
   parameter bit ABS_MODE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flow_start_i,
   input logic             chr_vld_i,
   input logic             first_hit_o,
   input logic             rule_hit_o,
   input logic [CNT_W-1:0] match_ofs_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] snap_q,
   input logic             seen_q
);

   localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_DIST);

   logic [CNT_W-1:0] span;
   assign span = ABS_MODE ? match_ofs_o : match_ofs_o - snap_q;

   assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_start_i && !chr_vld_i) |=> (cnt_q == '0));

   assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_start_i && chr_vld_i) |=> (cnt_q == CNT_W'(1)));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!chr_vld_i && !flow_start_i) |=> $stable(cnt_q));

   assert_ofs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rule_hit_o |-> $stable(match_ofs_o));

   assert_needs_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rule_hit_o |-> seen_q);

   assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rule_hit_o |-> (span < LIM));

   assert_lead_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      first_hit_o |-> seen_q);

endmodule

bind rm_dual_content_rule rm_rule_checker #(
   .CNT_W(CNT_W), .MAX_DIST(MAX_DIST),
   .ABS_MODE(POS_MODE == rm_pkg::POS_ABSOLUTE)
) u_rule_chk (
   .clk(clk), .rst_n(rst_n), .flow_start_i(flow_start_i), .chr_vld_i(chr_vld_i),
   .first_hit_o(first_hit_o), .rule_hit_o(rule_hit_o), .match_ofs_o(match_ofs_o),
   .cnt_q(cnt_q), .snap_q(snap_q), .seen_q(seen_q)
);

// File: tb/rm_dual_content_rule_bench.sv
module rm_dual_content_rule_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fs = 1'b0;
   logic          vld = 1'b0;
   logic [7:0]    chr = 8'h00;
   logic          r_first, r_rule, a_first, a_rule;
   logic [CW-1:0] r_ofs, a_ofs;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   // per-run observations
   int r_hits, r_hit_pos, r_firsts, r_first_pos, a_hits;

   always #(CLK_PERIOD/2) clk = ~clk;

   rm_dual_content_rule #(.CNT_W(CW)) u_rm_dual_content_rule (
      .clk(clk), .rst_n(rst_n), .flow_start_i(fs), .chr_vld_i(vld), .chr_i(chr),
      .first_hit_o(r_first), .rule_hit_o(r_rule), .match_ofs_o(r_ofs)
   );

   rm_dual_content_rule #(.CNT_W(CW), .POS_MODE(rm_pkg::POS_ABSOLUTE)) u_abs (
      .clk(clk), .rst_n(rst_n), .flow_start_i(fs), .chr_vld_i(vld), .chr_i(chr),
      .first_hit_o(a_first), .rule_hit_o(a_rule), .match_ofs_o(a_ofs)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Drive one cycle after a falling edge; observe at the next falling edge.
   task automatic put(bit start, bit v, byte c, int pos);
      fs  = start;
      vld = v;
      chr = c;
      @(negedge clk);
      fs  = 1'b0;
      vld = 1'b0;
      if (r_rule)  begin r_hits++;   r_hit_pos   = pos; end
      if (r_first) begin r_firsts++; r_first_pos = pos; end
      if (a_rule)  a_hits++;
   endtask

   // '.' means an idle cycle; a flow start marks the first element.
   task automatic run(string s, bit new_flow);
      r_hits = 0; r_hit_pos = -1; r_firsts = 0; r_first_pos = -1; a_hits = 0;
      for (int i = 0; i < s.len(); i++) begin
         put(new_flow && (i == 0), s[i] != ".", s[i], i);
      end
      put(1'b0, 1'b0, 8'h00, s.len());
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 first_hit in reset", r_first, 0);
      check("R1 rule_hit in reset", r_rule, 0);
      check("R1 match_ofs in reset", r_ofs, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rule_hit after reset", r_rule, 0);
      check("R1 match_ofs after reset", r_ofs, 0);
   endtask

   task automatic t_distance;
      run("abxxxxxxcde", 1'b1);       // distance 9
      check("R3 distance 9 hit count", r_hits, 1);
      check("R3 distance 9 pulse cycle", r_hit_pos, 10);
      check("R8 distance 9 offset", r_ofs, 10);
      run("abxxxxxxxcde", 1'b1);      // distance 10
      check("R3 distance 10 hit count", r_hits, 0);
      check("R8 offset held after miss", r_ofs, 10);
      run("abxxxxxxxxcde", 1'b1);     // distance 11
      check("R3 distance 11 hit count", r_hits, 0);
   endtask

   task automatic t_lead_pulse;
      run("abxab", 1'b1);
      check("R2 lead pulse count", r_firsts, 2);
      check("R2 last lead pulse cycle", r_first_pos, 4);
   endtask

   task automatic t_no_lead;
      run("xxcde", 1'b1);
      check("R4 trailing alone", r_hits, 0);
      run("cdeab", 1'b1);
      check("R4 trailing before leading", r_hits, 0);
      run("xcde", 1'b1);
      check("R4 absolute trailing alone", a_hits, 0);
   endtask

   task automatic t_overwrite;
      run("abxxxxxxxxabcde", 1'b1);
      check("R5 latest lead used", r_hits, 1);
      check("R5 offset", r_ofs, 14);
      check("R9 absolute late trailing", a_hits, 0);
   endtask

   task automatic t_flow_start;
      run("abx", 1'b1);
      run("abcde", 1'b1);
      check("R6 pulse byte is offset 0", r_hits, 1);
      check("R6 offset restarted", r_ofs, 4);
      run("xa", 1'b1);
      run("bcde", 1'b1);
      check("R6 prefix cleared lead", r_firsts, 0);
      check("R6 prefix cleared rule", r_hits, 0);
      run("ab", 1'b1);
      run("cde", 1'b1);
      check("R6 seen cleared", r_hits, 0);
      run(".abcde", 1'b1);
      check("R6 lone pulse hit", r_hits, 1);
      check("R6 lone pulse offset", r_ofs, 4);
   endtask

   task automatic t_idle;
      run("a.bxxxxxxc..de", 1'b1);
      check("R7 split contents hit", r_hits, 1);
      check("R7 pulse cycle", r_hit_pos, 13);
      check("R7 offset counts valid bytes", r_ofs, 10);
   endtask

   task automatic t_absolute;
      run("xxxxxxxabcde", 1'b1);
      check("R9 absolute beyond window", a_hits, 0);
      check("R3 relative same stream", r_hits, 1);
      run("xxxxabcde", 1'b1);
      check("R9 absolute inside window", a_hits, 1);
      check("R9 absolute offset", a_ofs, 8);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_distance();
      t_lead_pulse();
      t_no_lead();
      t_overwrite();
      t_flow_start();
      t_idle();
      t_absolute();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule